// File: doc/BRIEF.md
# Vector FP32 Truncate-to-Integral Unit

This unit accepts a 128-bit vector holding four IEEE-754 single-precision lanes. It rounds every lane toward zero to an integral value, and each result stays in single-precision encoding. A lane whose input is a signalling NaN comes out as the matching quiet NaN, and the unit pulses a flag that marks an invalid operation caused by a signalling NaN.

The unit also decides whether the destination may be written. With the exception-enable input high, one signalling NaN in any lane cancels the write of all four lanes. With the facility-enable input low, the unit raises an unavailable trap in place of a write or a flag.

All outputs are registered. Each accepted input produces a single cycle of write-enable, flag and trap pulses, and these appear one clock after the input is presented.

Top module: `fp32x4_trunc_unit`

## Requirements
- R1: Lane i occupies bits [32*i+31 : 32*i] of both `srcVec` and `resVec`, and each lane is computed from its own input lane only.
- R2: For a finite input with biased exponent field (bits 30:23) from 127 to 149, the result is the input with its low (150 - exponent field) bits cleared. This is truncation toward zero, and the result stays in FP32 encoding.
- R3: A finite input with biased exponent field below 127 (magnitude under 1.0, subnormals and zero included) gives a zero that keeps the input sign (bit 31).
- R4: Infinities (exponent field 255, fraction 0), zeros, and finite values with exponent field 150 or more are returned unchanged.
- R5: A signalling NaN (exponent field 255, fraction non-zero, fraction bit 22 clear) gives the same word with bit 22 set, and `snanFlagSet` pulses.
- R6: A quiet NaN (exponent field 255, bit 22 set) is returned unchanged and raises no flag.
- R7: `resWrite` pulses only when the input was valid, `facilityOn` was high, and `excEnable` was low or no lane held a signalling NaN. Otherwise all four lanes are left unwritten.
- R8: When `facilityOn` is low for a valid input, `unavailTrap` pulses and `resWrite` and `snanFlagSet` stay low.
- R9: Results and pulses appear in the cycle after `inValid` is sampled high. The pulses stay low in any cycle not preceded by a valid input.
- R10: While `rstN` is low, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input vector and controls are valid this cycle |
| srcVec | input | 128 | Four FP32 source lanes |
| excEnable | input | 1 | Enables the invalid-operation exception for signalling NaNs |
| facilityOn | input | 1 | Vector facility enabled; low makes a valid input trap |
| resVec | output | 128 | Registered truncated FP32 lanes |
| resWrite | output | 1 | Destination write-enable pulse |
| snanFlagSet | output | 1 | Sticky signalling-NaN flag set pulse |
| unavailTrap | output | 1 | Facility unavailable trap pulse |

## Verification
On every cycle the assertions check the control behaviour: the trap excludes a write or a flag, an enabled exception suppresses the write, a flag is traced back to a signalling NaN in the previous source, no written lane is ever a signalling NaN, and no pulse appears without a preceding valid input. Only the bench scenarios can show the arithmetic itself. It places every value class (fractional, sub-one, subnormal, signed zero, infinity, large integral, quiet and signalling NaN) in each of the four lane positions and compares the exact result words. The reset state is also covered by a directed test.

// File: rtl/trunc_pkg.sv
package trunc_pkg;
  localparam int FP_W = 32;
  localparam int MANT_W = 23;
  localparam logic [7:0] EXP_BIAS = 8'd127;   // exponent field of 1.0
  localparam logic [7:0] EXP_INTEGRAL = 8'd150; // from here no fraction bits remain
  localparam logic [7:0] EXP_SPECIAL = 8'hFF;
  localparam int QUIET_BIT = MANT_W - 1;

  typedef struct packed {
    logic loadRes;  // capture datapath result into the output register
  } dpStrobe_t;
endpackage

// File: rtl/trunc_lane.sv
module trunc_lane
  import trunc_pkg::*;
(
  input  logic [FP_W-1:0] laneIn,
  output logic [FP_W-1:0] laneOut,
  output logic            laneSnan
);
  logic              signBit;
  logic [7:0]        expField;
  logic [MANT_W-1:0] fracField;
  logic [7:0]        dropBits;
  logic [FP_W-1:0]   keepMask;

  assign signBit   = laneIn[FP_W-1];
  assign expField  = laneIn[FP_W-2:MANT_W];
  assign fracField = laneIn[MANT_W-1:0];
  assign dropBits  = EXP_INTEGRAL - expField;
  assign keepMask  = {FP_W{1'b1}} << dropBits;

  always_comb begin
    laneOut  = laneIn;
    laneSnan = 1'b0;
    if (expField == EXP_SPECIAL) begin
      if (fracField != '0 && !fracField[QUIET_BIT]) begin
        laneSnan = 1'b1;
        laneOut[QUIET_BIT] = 1'b1;
      end
    end else if (expField < EXP_BIAS) begin
      laneOut = {signBit, {(FP_W-1){1'b0}}};
    end else if (expField < EXP_INTEGRAL) begin
      laneOut = laneIn & keepMask;
    end
  end
endmodule

// File: rtl/trunc_datapath.sv
module trunc_datapath
  import trunc_pkg::*;
#(
  parameter int LANES = 4,
  localparam int VW = LANES * FP_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [VW-1:0] srcVec,
  input  dpStrobe_t     strb,
  output logic          anySnan,
  output logic [VW-1:0] resVec
);
  logic [VW-1:0]    laneRes;
  logic [LANES-1:0] laneSnan;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    trunc_lane u_lane (
      .laneIn  (srcVec[g*FP_W +: FP_W]),
      .laneOut (laneRes[g*FP_W +: FP_W]),
      .laneSnan(laneSnan[g])
    );
  end

  assign anySnan = |laneSnan;

  always_ff @(posedge clk) begin
    if (!rstN) resVec <= '0;
    else if (strb.loadRes) resVec <= laneRes;
  end
endmodule

// File: rtl/trunc_ctrl.sv
module trunc_ctrl
  import trunc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      excEnable,
  input  logic      facilityOn,
  input  logic      anySnan,
  output dpStrobe_t strb,
  output logic      resWrite,
  output logic      snanFlagSet,
  output logic      unavailTrap
);
  logic accept;
  logic excHit;

  assign accept       = inValid && facilityOn;
  assign excHit       = excEnable && anySnan;
  assign strb.loadRes = accept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resWrite    <= 1'b0;
      snanFlagSet <= 1'b0;
      unavailTrap <= 1'b0;
    end else begin
      resWrite    <= accept && !excHit;
      snanFlagSet <= accept && anySnan;
      unavailTrap <= inValid && !facilityOn;
    end
  end
endmodule

// File: rtl/fp32x4_trunc_unit.sv
module fp32x4_trunc_unit
  import trunc_pkg::*;
#(
  parameter int LANES = 4,
  localparam int VW = LANES * FP_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [VW-1:0] srcVec,
  input  logic          excEnable,
  input  logic          facilityOn,
  output logic [VW-1:0] resVec,
  output logic          resWrite,
  output logic          snanFlagSet,
  output logic          unavailTrap
);
  dpStrobe_t strb;
  logic      anySnan;

  trunc_datapath #(.LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .srcVec(srcVec), .strb(strb),
    .anySnan(anySnan), .resVec(resVec)
  );

  trunc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .excEnable(excEnable),
    .facilityOn(facilityOn), .anySnan(anySnan), .strb(strb),
    .resWrite(resWrite), .snanFlagSet(snanFlagSet), .unavailTrap(unavailTrap)
  );
endmodule

// File: rtl/fp32x4_trunc_checker.sv
module fp32x4_trunc_checker
  import trunc_pkg::*;
#(
  parameter int LANES = 4,
  localparam int VW = LANES * FP_W
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic [VW-1:0] srcVec,
  input logic          excEnable,
  input logic          facilityOn,
  input logic [VW-1:0] resVec,
  input logic          resWrite,
  input logic          snanFlagSet,
  input logic          unavailTrap
);
  function automatic logic hasSnan(input logic [VW-1:0] v);
    logic hit = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (v[i*FP_W+MANT_W +: 8] == 8'hFF && v[i*FP_W+QUIET_BIT] == 1'b0
          && v[i*FP_W +: QUIET_BIT] != '0)
        hit = 1'b1;
    end
    return hit;
  endfunction

  // R8: a trap never coincides with a write or a flag
  p_trap_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    unavailTrap |-> (!resWrite && !snanFlagSet));

  // R7: enabled exception with a flagged lane suppresses the write
  p_suppress_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (snanFlagSet && $past(excEnable)) |-> !resWrite);

  // R7: with the exception disabled an accepted vector is always written
  p_write_no_exc_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && facilityOn && !excEnable) |-> resWrite);

  // R5: a flag traces back to a signalling NaN in the source
  p_flag_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    snanFlagSet |-> hasSnan($past(srcVec)));

  // R5: a written vector never carries a signalling NaN
  p_quiet_output_r5: assert property (@(posedge clk) disable iff (!rstN)
    resWrite |-> !hasSnan(resVec));

  // R9: no pulse without a valid input in the previous cycle
  p_no_idle_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> (!resWrite && !snanFlagSet && !unavailTrap));
endmodule

bind fp32x4_trunc_unit fp32x4_trunc_checker #(.LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .srcVec(srcVec),
  .excEnable(excEnable), .facilityOn(facilityOn), .resVec(resVec),
  .resWrite(resWrite), .snanFlagSet(snanFlagSet), .unavailTrap(unavailTrap)
);

// File: tb/fp32x4_trunc_unit_test.sv
`timescale 1ns/1ps
module fp32x4_trunc_unit_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] srcVec = '0;
  logic         excEnable = 1'b0;
  logic         facilityOn = 1'b1;
  logic [127:0] resVec;
  logic         resWrite, snanFlagSet, unavailTrap;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fp32x4_trunc_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcVec(srcVec),
    .excEnable(excEnable), .facilityOn(facilityOn), .resVec(resVec),
    .resWrite(resWrite), .snanFlagSet(snanFlagSet), .unavailTrap(unavailTrap)
  );

  // {source word, expected word, expected signalling flag}
  localparam int NV = 20;
  localparam logic [64:0] VEC [NV] = '{
    {32'h3F800000, 32'h3F800000, 1'b0},  // 1.0            R2
    {32'h3FC00000, 32'h3F800000, 1'b0},  // 1.5 -> 1.0     R2
    {32'hC0300000, 32'hC0000000, 1'b0},  // -2.75 -> -2.0  R2
    {32'h42F6E979, 32'h42F60000, 1'b0},  // 123.456 -> 123 R2
    {32'h3FFFFFFF, 32'h3F800000, 1'b0},  // 1.99.. -> 1.0  R2
    {32'h4AFFFFFF, 32'h4AFFFFFE, 1'b0},  // exp 149        R2
    {32'hBF333333, 32'h80000000, 1'b0},  // -0.7 -> -0     R3
    {32'h3F000000, 32'h00000000, 1'b0},  // 0.5 -> +0      R3
    {32'h00000001, 32'h00000000, 1'b0},  // subnormal      R3
    {32'h80400000, 32'h80000000, 1'b0},  // -subnormal     R3
    {32'h00000000, 32'h00000000, 1'b0},  // +0             R4
    {32'h80000000, 32'h80000000, 1'b0},  // -0             R4
    {32'h7F800000, 32'h7F800000, 1'b0},  // +inf           R4
    {32'hFF800000, 32'hFF800000, 1'b0},  // -inf           R4
    {32'h4B000001, 32'h4B000001, 1'b0},  // exp 150        R4
    {32'h4F000000, 32'h4F000000, 1'b0},  // 2^31           R4
    {32'h7F800001, 32'h7FC00001, 1'b1},  // sNaN           R5
    {32'hFFA00000, 32'hFFE00000, 1'b1},  // -sNaN          R5
    {32'h7FC00000, 32'h7FC00000, 1'b0},  // qNaN           R6
    {32'hFFC12345, 32'hFFC12345, 1'b0}   // qNaN payload   R6
  };

  localparam logic [31:0] FILL_IN  = 32'h40200000;  // 2.5
  localparam logic [31:0] FILL_OUT = 32'h40000000;  // 2.0

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present one vector for one cycle; outputs are sampled at the next negedge
  task automatic apply(input logic [127:0] v, input logic exc, input logic fac);
    @(negedge clk);
    srcVec = v; excEnable = exc; facilityOn = fac; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 resVec", resVec, '0);
    chk("R10 pulses", {125'b0, resWrite, snanFlagSet, unavailTrap}, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", {125'b0, resWrite, snanFlagSet, unavailTrap}, '0);

    // table walk: every entry in every lane position (R1..R6)
    for (int k = 0; k < NV; k++) begin
      for (int ln = 0; ln < 4; ln++) begin
        logic [127:0] v, e;
        v = {4{FILL_IN}};
        e = {4{FILL_OUT}};
        v[ln*32 +: 32] = VEC[k][64:33];
        e[ln*32 +: 32] = VEC[k][32:1];
        apply(v, 1'b0, 1'b1);
        chk("R1/R2/R3/R4 lane value", resVec, e);
        chk("R5/R6 flag", {127'b0, snanFlagSet}, {127'b0, VEC[k][0]});
        chk("R7 write with exception off", {127'b0, resWrite}, 128'd1);
      end
    end

    // R7: enabled exception, sNaN in lane 2 -> no write, flag set
    apply({32'h3FC00000, 32'h7F800001, 32'h3FC00000, 32'h3FC00000}, 1'b1, 1'b1);
    chk("R7 suppressed write", {127'b0, resWrite}, '0);
    chk("R5 flag with exception on", {127'b0, snanFlagSet}, 128'd1);
    // R7: enabled exception, no sNaN -> write
    apply({4{32'h3FC00000}}, 1'b1, 1'b1);
    chk("R7 write without sNaN", {127'b0, resWrite}, 128'd1);
    chk("R7 value", resVec, {4{32'h3F800000}});
    // R6 + R7: quiet NaN with exception on still writes
    apply({32'h7FC00000, {3{32'h3FC00000}}}, 1'b1, 1'b1);
    chk("R6 qNaN write", {126'b0, resWrite, snanFlagSet}, 128'd2);
    // R8: facility off with sNaN -> trap only
    apply({4{32'h7F800001}}, 1'b1, 1'b0);
    chk("R8 trap pulses", {125'b0, resWrite, snanFlagSet, unavailTrap}, 128'd1);
    // R9: pulses drop after one cycle
    @(negedge clk);
    chk("R9 single-cycle pulses", {125'b0, resWrite, snanFlagSet, unavailTrap}, '0);
    // R10: reset mid-run clears outputs
    rstN = 1'b0;
    @(negedge clk);
    chk("R10 reset clears resVec", resVec, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule